// File: doc/BRIEF.md
# Hardware Watchpoint Match Unit

This block watches the memory accesses of a core and raises a trap when one of them falls on an address that software has marked for debugging. It has four address slots, one control register and one status register. All of them sit behind a small register port that takes a 3-bit index, a write strobe and write data, and gives back read data without a clock. Indices 0 to 3 select the address slots, index 6 the status register and index 7 the control register. Indices 4 and 5 read as zero, and writes to them do nothing.

Every cycle the unit takes an access bus: a valid strobe, an address and a 2-bit access kind. It compares the access against every active slot at once. Each slot has its own access-kind qualifier, its own length qualifier and two enables. When at least one slot matches, the unit sets one sticky status bit per matching slot and pulses a registered trap output. Two event inputs also set status bits: single-step and task switch. A task switch also clears every slot's local enable, and leaves the global enables set.

Top module: `watch_unit`

## Requirements
- R1: After reset, every register (four slot addresses, status and control) reads as zero and `trap_o` is low.
- R2: A write to index 0 to 3 stores a slot address that reads back unchanged. Indices 4 and 5 read as zero.
- R3: Control bits 8 and 9 are stored and read back. Control bits 10 to 15 always read as zero, whatever is written to them.
- R4: The 4-bit field for slot n sits at control bits 16+4n upward. Its low two bits give the kind of access that can hit: 00 matches only a fetch access, 01 only a write access and 11 only a read access. The `acc_kind` input uses the same codes. A field code of 10 never matches, and an access with kind 10 never matches either.
- R5: The high two bits of the slot field give the length. 00 compares the whole address. 01 ignores address bit 0. 11 ignores address bits 1:0. 10 never matches.
- R6: Control bit 2n is the local enable of slot n and bit 2n+1 is its global enable. A slot takes part in matching only when at least one of the two is set.
- R7: A cycle with `tswitch_evt` high clears every local enable bit, keeps the global enable bits and sets status bit 15. This happens even when the same cycle writes the control register.
- R8: A cycle with `step_evt` high sets status bit 14.
- R9: Status bits are sticky. Only a write to index 6 clears them. Such a write stores data bits 0 to 3, 14 and 15 and reads every other status bit as zero. Bits set by events or hits in the same cycle are ORed on top of the written value.
- R10: When several slots match the same access, all of their status bits (bit n for slot n) are set in the same cycle.
- R11: `trap_o` is high for exactly the cycle after a valid access that matches at least one active slot. It is low otherwise. An access with `acc_valid` low matches nothing and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register (combinational) |
| acc_valid | input | 1 | Access bus valid strobe |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 write, 11 read |
| step_evt | input | 1 | Single-step event |
| tswitch_evt | input | 1 | Task-switch event |
| trap_o | output | 1 | Registered trap pulse on a watchpoint hit |

## Verification
Directed cases try each kind code against each access kind. This separates a kind decode that is swapped or too loose from a correct one. Lengths are tried with addresses one and two bytes past the slot base and one byte past the masked span, which pins the exact number of ignored bits. Enable-only-local, enable-only-global and no-enable cases, together with a task switch, tell the two enable bits apart. A long random run then mixes accesses aimed near the slot addresses with register writes and events, and compares trap and status against a model every cycle. This catches faults in priority and stickiness that only show up when events overlap.

// File: rtl/watch_pkg.sv
`timescale 1ns/1ps
package watch_pkg;
  localparam int REG_W         = 32;
  localparam int IDX_W         = 3;
  localparam int MAX_SLOTS     = 4;
  localparam int STAT_STEP_BIT = 14;
  localparam int STAT_TSW_BIT  = 15;
  localparam int SLOW_LO_BIT   = 8;
  localparam int SLOW_HI_BIT   = 9;
  localparam int FIELD_BASE    = 16;
  localparam int FIELD_W       = 4;

  localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_CONTROL = 3'd7;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_RSVD  = 2'b10,
    KIND_READ  = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    LEN_BYTE = 2'b00,
    LEN_HALF = 2'b01,
    LEN_BAD  = 2'b10,
    LEN_WORD = 2'b11
  } len_e;

  // even enable bit of each slot
  function automatic logic [REG_W-1:0] local_en_mask(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  // writable control bits for n slots
  function automatic logic [REG_W-1:0] ctrl_keep_mask(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) begin
      m[2*i]   = 1'b1;
      m[2*i+1] = 1'b1;
      m[FIELD_BASE + FIELD_W*i +: FIELD_W] = '1;
    end
    m[SLOW_LO_BIT] = 1'b1;
    m[SLOW_HI_BIT] = 1'b1;
    return m;
  endfunction

  // implemented status bits for n slots
  function automatic logic [REG_W-1:0] stat_keep_mask(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    m[STAT_STEP_BIT] = 1'b1;
    m[STAT_TSW_BIT]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/watch_slot_cmp.sv
`timescale 1ns/1ps
module watch_slot_cmp
  import watch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              en_local,
  input  logic              en_global,
  input  logic [FIELD_W-1:0] field,
  output logic              hit
);
  logic [1:0]        kind_sel;
  logic [1:0]        len_sel;
  logic [ADDR_W-1:0] ign_bits;
  logic              len_ok;
  logic              kind_ok;
  logic              addr_ok;

  assign kind_sel = field[1:0];
  assign len_sel  = field[3:2];

  always_comb begin
    ign_bits = '0;
    len_ok   = 1'b1;
    case (len_sel)
      LEN_BYTE: ign_bits = '0;
      LEN_HALF: ign_bits[0] = 1'b1;
      LEN_WORD: ign_bits[1:0] = 2'b11;
      default:  len_ok = 1'b0;
    endcase
  end

  assign kind_ok = (kind_sel != KIND_RSVD) && (acc_kind == kind_sel);
  assign addr_ok = ((acc_addr ^ slot_addr) & ~ign_bits) == '0;
  assign hit     = acc_valid && (en_local || en_global) && kind_ok && len_ok && addr_ok;
endmodule

// File: rtl/watch_cfg_regs.sv
`timescale 1ns/1ps
module watch_cfg_regs
  import watch_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              tsw_evt,
  output logic [ADDR_W-1:0] slot_addr [NUM_SLOTS],
  output logic [REG_W-1:0]  ctrl_q
);
  localparam logic [REG_W-1:0] CTRL_KEEP = ctrl_keep_mask(NUM_SLOTS);
  localparam logic [REG_W-1:0] LOCAL_EN  = local_en_mask(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] addr_we;
  logic                 ctrl_we;
  logic                 ctrl_en;
  logic [REG_W-1:0]     ctrl_d;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_addr
    assign addr_we[g] = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr[g] <= '0;
      end else if (addr_we[g]) begin
        slot_addr[g] <= wr_data[ADDR_W-1:0];
      end
    end
  end

  assign ctrl_we = wr_en && (wr_idx == IDX_CONTROL);
  assign ctrl_en = ctrl_we || tsw_evt;

  always_comb begin
    ctrl_d = ctrl_we ? (wr_data & CTRL_KEEP) : ctrl_q;
    if (tsw_evt) ctrl_d = ctrl_d & ~LOCAL_EN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/watch_status_reg.sv
`timescale 1ns/1ps
module watch_status_reg
  import watch_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [NUM_SLOTS-1:0] hit_vec,
  input  logic                 step_evt,
  input  logic                 tsw_evt,
  output logic [REG_W-1:0]     status_q,
  output logic                 trap_q
);
  localparam logic [REG_W-1:0] STAT_KEEP = stat_keep_mask(NUM_SLOTS);

  logic [REG_W-1:0] set_bits;
  logic [REG_W-1:0] base;
  logic [REG_W-1:0] status_d;
  logic             stat_en;
  logic             trap_d;

  always_comb begin
    set_bits = '0;
    set_bits[NUM_SLOTS-1:0]  = hit_vec;
    set_bits[STAT_STEP_BIT]  = step_evt;
    set_bits[STAT_TSW_BIT]   = tsw_evt;
    base     = wr_en ? (wr_data & STAT_KEEP) : status_q;
    status_d = base | set_bits;
    stat_en  = wr_en || (|set_bits);
    trap_d   = |hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (stat_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
    end else begin
      trap_q <= trap_d;
    end
  end
endmodule

// File: rtl/watch_unit.sv
`timescale 1ns/1ps
module watch_unit
  import watch_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              step_evt,
  input  logic              tswitch_evt,
  output logic              trap_o
);
  logic [ADDR_W-1:0]    slot_addr [NUM_SLOTS];
  logic [REG_W-1:0]     ctrl_q;
  logic [REG_W-1:0]     status_q;
  logic [NUM_SLOTS-1:0] hit_vec;
  logic [NUM_SLOTS-1:0] slot_en;
  logic                 wr_status;

  assign wr_status = reg_we && (reg_idx == IDX_STATUS);

  watch_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_we),
    .wr_idx    (reg_idx),
    .wr_data   (reg_wdata),
    .tsw_evt   (tswitch_evt),
    .slot_addr (slot_addr),
    .ctrl_q    (ctrl_q)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_en[g] = ctrl_q[2*g] | ctrl_q[2*g+1];

    watch_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_kind  (acc_kind),
      .slot_addr (slot_addr[g]),
      .en_local  (ctrl_q[2*g]),
      .en_global (ctrl_q[2*g+1]),
      .field     (ctrl_q[FIELD_BASE + FIELD_W*g +: FIELD_W]),
      .hit       (hit_vec[g])
    );
  end

  watch_status_reg #(.NUM_SLOTS(NUM_SLOTS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_status),
    .wr_data  (reg_wdata),
    .hit_vec  (hit_vec),
    .step_evt (step_evt),
    .tsw_evt  (tswitch_evt),
    .status_q (status_q),
    .trap_q   (trap_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_idx == IDX_STATUS) begin
      reg_rdata = status_q;
    end else if (reg_idx == IDX_CONTROL) begin
      reg_rdata = ctrl_q;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (int'(reg_idx) == i) reg_rdata = REG_W'(slot_addr[i]);
      end
    end
  end
endmodule

// File: rtl/watch_unit_chk.sv
`timescale 1ns/1ps
module watch_unit_chk
  import watch_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [IDX_W-1:0]     reg_idx,
  input logic                 acc_valid,
  input logic [1:0]           acc_kind,
  input logic                 step_evt,
  input logic                 tswitch_evt,
  input logic [NUM_SLOTS-1:0] hit_vec,
  input logic [NUM_SLOTS-1:0] slot_en,
  input logic [REG_W-1:0]     ctrl_q,
  input logic [REG_W-1:0]     status_q,
  input logic                 trap_o
);
  localparam logic [REG_W-1:0] LOCAL_EN = local_en_mask(NUM_SLOTS);

  a_r4_rsvd_kind_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == KIND_RSVD) |-> (hit_vec == '0));

  a_r6_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~slot_en) == '0);

  a_r7_tsw_clears_local: assert property (@(posedge clk) disable iff (!rst_n)
    tswitch_evt |=> (((ctrl_q & LOCAL_EN) == '0) && status_q[STAT_TSW_BIT]));

  a_r8_step_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> status_q[STAT_STEP_BIT]);

  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_idx == IDX_STATUS)) |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r10_all_hits_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> ((status_q[NUM_SLOTS-1:0] & $past(hit_vec)) == $past(hit_vec)));

  a_r11_trap_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> trap_o);

  a_r11_no_trap_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit_vec) |=> !trap_o);

  a_r11_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (hit_vec == '0));
endmodule

bind watch_unit watch_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_idx     (reg_idx),
  .acc_valid   (acc_valid),
  .acc_kind    (acc_kind),
  .step_evt    (step_evt),
  .tswitch_evt (tswitch_evt),
  .hit_vec     (hit_vec),
  .slot_en     (slot_en),
  .ctrl_q      (ctrl_q),
  .status_q    (status_q),
  .trap_o      (trap_o)
);

// File: tb/watch_unit_bench.sv
`timescale 1ns/1ps
module watch_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [1:0]  acc_kind;
  logic        step_evt;
  logic        tswitch_evt;
  logic        trap_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_addr [4];
  logic [31:0] m_ctrl;
  logic [31:0] m_stat;
  logic        m_trap;

  watch_unit u_watch_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .step_evt(step_evt),
    .tswitch_evt(tswitch_evt), .trap_o(trap_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [3:0] m_hits(input logic v, input logic [31:0] a, input logic [1:0] k);
    logic [3:0] h;
    h = '0;
    for (int n = 0; n < 4; n++) begin
      logic [3:0]  f;
      logic [31:0] ign;
      logic        ok;
      f   = m_ctrl[16 + 4*n +: 4];
      ok  = v && (m_ctrl[2*n] || m_ctrl[2*n+1]) && (f[1:0] != 2'b10) && (k == f[1:0]);
      ign = (f[3:2] == 2'b01) ? 32'h1 : (f[3:2] == 2'b11) ? 32'h3 : 32'h0;
      if (f[3:2] == 2'b10) ok = 1'b0;
      if (((a ^ m_addr[n]) & ~ign) != 0) ok = 1'b0;
      h[n] = ok;
    end
    return h;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] idx);
    if (idx < 3'd4) return m_addr[idx[1:0]];
    if (idx == 3'd6) return m_stat;
    if (idx == 3'd7) return m_ctrl;
    return 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_reg(input logic [2:0] idx, input string tag);
    reg_we  = 1'b0;
    reg_idx = idx;
    #1;
    chk(reg_rdata, m_read(idx), tag);
  endtask

  // one clock: inputs driven now (just after a negedge), checked at next negedge
  task automatic tick(input logic we, input logic [2:0] idx, input logic [31:0] wd,
                      input logic v, input logic [31:0] a, input logic [1:0] k,
                      input logic st, input logic ts, input string tag);
    logic [3:0]  h;
    logic [31:0] ns;
    logic [31:0] nc;
    reg_we = we; reg_idx = idx; reg_wdata = wd;
    acc_valid = v; acc_addr = a; acc_kind = k;
    step_evt = st; tswitch_evt = ts;
    h  = m_hits(v, a, k);
    ns = ((we && idx == 3'd6) ? (wd & 32'h0000_C00F) : m_stat) | {16'h0, ts, st, 10'h0, h};
    nc = (we && idx == 3'd7) ? (wd & 32'hFFFF_03FF) : m_ctrl;
    if (ts) nc = nc & ~32'h55;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0; step_evt = 1'b0; tswitch_evt = 1'b0;
    if (we && idx < 3'd4) m_addr[idx[1:0]] = wd;
    m_stat = ns;
    m_ctrl = nc;
    m_trap = |h;
    chk({31'h0, trap_o}, {31'h0, m_trap}, tag);
    check_reg(3'd6, tag);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d, input string tag);
    tick(1'b1, idx, d, 1'b0, 32'h0, 2'b00, 1'b0, 1'b0, tag);
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] k, input string tag);
    tick(1'b0, 3'd0, 32'h0, 1'b1, a, k, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    tick(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 2'b00, 1'b0, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; reg_we = 1'b0; reg_idx = 3'd0; reg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_kind = 2'b00;
    step_evt = 1'b0; tswitch_evt = 1'b0;
    for (int i = 0; i < 4; i++) m_addr[i] = '0;
    m_ctrl = '0; m_stat = '0; m_trap = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk({31'h0, trap_o}, 32'h0, "R1 trap");
    for (int i = 0; i < 8; i++) begin
      reg_idx = 3'(i); #1;
      chk(reg_rdata, 32'h0, "R1 reg");
    end

    // R2 address registers and holes
    wr(3'd0, 32'h0000_1000, "R2 wr");
    wr(3'd1, 32'h0000_2002, "R2 wr");
    wr(3'd2, 32'h0000_3004, "R2 wr");
    wr(3'd3, 32'hFFFF_FFFF, "R2 wr");
    wr(3'd4, 32'hDEAD_BEEF, "R2 hole");
    for (int i = 0; i < 6; i++) check_reg(3'(i), "R2 readback");
    reg_idx = 3'd1; #1; chk(reg_rdata, 32'h0000_2002, "R2 slot1");

    // R3 reserved control bits
    wr(3'd7, 32'hFFFF_FFFF, "R3 wr");
    reg_idx = 3'd7; #1; chk(reg_rdata, 32'hFFFF_03FF, "R3 ctrl mask");
    wr(3'd7, 32'h0000_0300, "R3 slowdown");
    reg_idx = 3'd7; #1; chk(reg_rdata, 32'h0000_0300, "R3 slowdown");

    // R4 kind qualifiers, slot0 global, len byte
    wr(3'd7, 32'h0001_0002, "R4 cfg");
    acc(32'h1000, 2'b01, "R4 write hits");
    chk(m_stat, 32'h1, "R4 model");
    acc(32'h1000, 2'b11, "R4 read misses write slot");
    acc(32'h1000, 2'b00, "R4 fetch misses write slot");
    wr(3'd6, 32'h0, "R4 clr");
    wr(3'd7, 32'h0000_0002, "R4 fetch cfg");
    acc(32'h1000, 2'b00, "R4 fetch hits");
    acc(32'h1000, 2'b10, "R4 rsvd kind");
    wr(3'd7, 32'h0003_0002, "R4 read cfg");
    acc(32'h1000, 2'b11, "R4 read hits");
    acc(32'h1000, 2'b01, "R4 write misses read slot");
    wr(3'd7, 32'h0002_0002, "R4 rsvd cfg");
    for (int k = 0; k < 4; k++) acc(32'h1000, 2'(k), "R4 rsvd code never");
    wr(3'd6, 32'h0, "R4 clr");

    // R5 length masking
    wr(3'd7, 32'h0005_0002, "R5 half cfg");
    acc(32'h1001, 2'b01, "R5 half offset1 hits");
    acc(32'h1002, 2'b01, "R5 half offset2 misses");
    wr(3'd7, 32'h000D_0002, "R5 word cfg");
    acc(32'h1003, 2'b01, "R5 word offset3 hits");
    acc(32'h1004, 2'b01, "R5 word offset4 misses");
    wr(3'd7, 32'h0001_0002, "R5 byte cfg");
    acc(32'h1001, 2'b01, "R5 byte offset1 misses");
    wr(3'd7, 32'h0009_0002, "R5 bad len cfg");
    acc(32'h1000, 2'b01, "R5 bad len never");
    wr(3'd6, 32'h0, "R5 clr");

    // R6 enables
    wr(3'd7, 32'h0001_0000, "R6 none");
    acc(32'h1000, 2'b01, "R6 disabled misses");
    wr(3'd7, 32'h0001_0001, "R6 local");
    acc(32'h1000, 2'b01, "R6 local hits");
    wr(3'd6, 32'h0, "R6 clr");

    // R7 task switch, slot0 local + slot1 global
    wr(3'd7, 32'h0000_0009, "R7 cfg");
    tick(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 2'b00, 1'b0, 1'b1, "R7 tsw");
    reg_idx = 3'd7; #1; chk(reg_rdata, 32'h0000_0008, "R7 local cleared");
    reg_idx = 3'd6; #1; chk(reg_rdata, 32'h0000_8000, "R7 status bit15");
    tick(1'b1, 3'd7, 32'h0000_0003, 1'b0, 32'h0, 2'b00, 1'b0, 1'b1, "R7 tsw over wr");
    check_reg(3'd7, "R7 tsw over wr ctrl");

    // R8 single step
    tick(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 2'b00, 1'b1, 1'b0, "R8 step");
    reg_idx = 3'd6; #1; chk(reg_rdata, 32'h0000_C000, "R8 status bit14");

    // R9 stickiness and write semantics
    idle("R9 sticky idle");
    idle("R9 sticky idle");
    wr(3'd6, 32'hFFFF_FFFF, "R9 wr ones");
    reg_idx = 3'd6; #1; chk(reg_rdata, 32'h0000_C00F, "R9 stored bits");
    wr(3'd6, 32'h0, "R9 clr");
    tick(1'b1, 3'd6, 32'h0, 1'b0, 32'h0, 2'b00, 1'b1, 1'b0, "R9 set over clear");
    reg_idx = 3'd6; #1; chk(reg_rdata, 32'h0000_4000, "R9 set over clear");
    wr(3'd6, 32'h0, "R9 clr");

    // R10 two slots on one access
    wr(3'd1, 32'h0000_1000, "R10 slot1");
    wr(3'd7, 32'h0033_000A, "R10 cfg");
    acc(32'h1000, 2'b11, "R10 both hit");
    reg_idx = 3'd6; #1; chk(reg_rdata, 32'h0000_0003, "R10 bits");
    wr(3'd6, 32'h0, "R10 clr");

    // R11 trap timing and invalid access
    tick(1'b0, 3'd0, 32'h0, 1'b0, 32'h1000, 2'b11, 1'b0, 1'b0, "R11 invalid ignored");
    acc(32'h1000, 2'b11, "R11 trap pulse");
    chk({31'h0, trap_o}, 32'h1, "R11 trap high");
    idle("R11 trap drops");
    chk({31'h0, trap_o}, 32'h0, "R11 trap low");

    // random mix
    for (int c = 0; c < 600; c++) begin
      int op;
      op = int'($urandom % 16);
      case (op)
        0: wr(3'd7, $urandom, "R4 R5 R6 rand ctrl");
        1: wr(3'($urandom % 4), $urandom, "R2 rand addr");
        2: wr(3'd6, $urandom, "R9 rand status");
        3: tick(1'b0, 3'd0, 32'h0, 1'b1, m_addr[$urandom % 4] ^ ($urandom % 8),
                2'($urandom), 1'b1, 1'b0, "R8 rand step");
        4: tick(1'b0, 3'd0, 32'h0, 1'b0, 32'h0, 2'b00, 1'b0, 1'b1, "R7 rand tsw");
        default: tick(1'b0, 3'd0, 32'h0, ($urandom % 8) != 0,
                      m_addr[$urandom % 4] ^ ($urandom % 8), 2'($urandom),
                      1'b0, 1'b0, "R11 rand access");
      endcase
      if (c % 8 == 0) check_reg(3'($urandom % 8), "R2 R3 rand read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule